// File: doc/BRIEF.md
# Temperature Limit Interrupt Controller

This block turns fresh local and remote temperature readings into interrupt signals. Each reading pair is compared with programmable window limits and with over-temperature trip points. The results drive three active-low, open-drain style outputs, each modelled as a pull-down enable:

- **Alert**: a latched, maskable output.
- **Therm**: a self-clearing, unmaskable output with hysteresis.
- **Shared pin**: this pin either repeats the alert or acts as a second hysteretic over-temperature output against the high limits.

A five-bit sticky status word records which condition fired. Once set, the alert holds until two things have both happened: a bus master has serviced it with an alert-response pulse, and software has cleared the status word.

Readings enter as a stream beat on `rd_valid`/`rd_ready`. The block never applies back-pressure, so `rd_ready` is always high. A beat is taken on every cycle where `rd_valid` is high. The temperature and open-fault inputs are sampled only on those cycles. All limits, the hysteresis, the mask and the pin mode are plain level inputs. They are expected to come from a register file that resets the two trip points to 85 and the hysteresis to 10.

Temperatures and limits are 8-bit two's complement whole degrees. The hysteresis is unsigned.

Top module: `tlim_irq_ctrl`

## Requirements
- R1: A taken beat with a temperature strictly above its high limit sets the status bit for that channel on the next cycle; a temperature equal to the limit does not. Status bit 4 is local high and bit 1 is remote high.
- R2: A taken beat with a temperature at or below its low limit sets the low bit for that channel. Status bit 3 is local low and bit 0 is remote low.
- R3: A taken beat with `open_fault` high sets status bit 2.
- R4: Status bits stay set until `status_clr`. If a condition is still present on a beat taken in the same cycle as the clear, its bit stays set. Reset clears all status bits.
- R5: The alert latch sets on the cycle after a taken beat that raises any condition. `alert_pd` shows the latch only while `alert_mask` is low; the mask acts combinationally and does not alter the latch.
- R6: The alert latch clears only on an edge where the status word is already zero and an `alert_serviced` pulse is seen, either in that cycle or earlier while the latch was set. A service pulse alone, or a status clear alone, leaves the latch set.
- R7: `therm_pd` is the OR of two per-channel states. A state sets on a taken beat with temperature above its trip point. It clears on a taken beat with temperature at or below the trip point minus the hysteresis, where that difference saturates at -128. Otherwise it holds.
- R8: When `pin2_mode` is 1, `pin2_pd` is the OR of two per-channel states built as in R7 but against the high limits. When `pin2_mode` is 0, `pin2_pd` equals `alert_pd`.
- R9: `alert_mask` has no effect on `therm_pd`, or on `pin2_pd` when `pin2_mode` is 1.
- R10: `rd_ready` is always 1. With `rd_valid` low, the temperature and fault inputs change neither the status word nor the therm states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_valid | input | 1 | Reading beat valid |
| rd_ready | output | 1 | Always 1 |
| loc_temp | input | TW | Local reading, signed |
| rem_temp | input | TW | Remote reading, signed |
| loc_high_lim | input | TW | Local high limit |
| loc_low_lim | input | TW | Local low limit |
| rem_high_lim | input | TW | Remote high limit |
| rem_low_lim | input | TW | Remote low limit |
| loc_therm_lim | input | TW | Local trip point |
| rem_therm_lim | input | TW | Remote trip point |
| therm_hyst | input | HW | Shared hysteresis, unsigned |
| alert_mask | input | 1 | 1 hides the alert |
| pin2_mode | input | 1 | 0 = alert, 1 = second therm |
| open_fault | input | 1 | Remote diode open |
| alert_serviced | input | 1 | Alert-response service pulse |
| status_clr | input | 1 | Status clear strobe |
| status | output | 5 | Sticky flags |
| alert_pd | output | 1 | Alert pull-down enable |
| therm_pd | output | 1 | Therm pull-down enable |
| pin2_pd | output | 1 | Shared pin pull-down enable |

## Verification
The trip-point and high-limit paths are swept one degree at a time, upward then downward, across the whole signed range. Each sweep is repeated for hysteresis values of 0, 10 and 200 and for trip points near the top, in the middle and near the bottom of the range. This separates the strict greater-than set point from the inclusive release point, and exposes a missing saturation at -128.

Directed sequences then apply service and clear in both orders, a clear that coincides with a persisting condition, and readings held back by a low `rd_valid`. Together these show which inputs alone cannot release the alert.

A long pseudo-random mix of readings, strobes and modes is checked against an arithmetic model on every cycle.

// File: rtl/tlim_pkg.sv
package tlim_pkg;
  localparam int ST_W     = 5;
  localparam int ST_RLOW  = 0;
  localparam int ST_RHIGH = 1;
  localparam int ST_OPEN  = 2;
  localparam int ST_LLOW  = 3;
  localparam int ST_LHIGH = 4;
  localparam int N_CH     = 2;

  typedef enum logic {
    PIN_ALERT  = 1'b0,
    PIN_THERM2 = 1'b1
  } pin_mode_e;
endpackage

// File: rtl/tlim_hyst_cmp.sv
module tlim_hyst_cmp #(
  parameter int TW = 8,
  parameter int HW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 upd,
  input  logic signed [TW-1:0] temp,
  input  logic signed [TW-1:0] lim,
  input  logic        [HW-1:0] hyst,
  output logic                 active
);
  localparam int EW = ((TW > HW) ? TW : HW) + 2;

  logic signed [EW-1:0] lim_x, hyst_x, diff_x, floor_x;
  logic signed [TW-1:0] thr;
  logic above, released;

  assign lim_x   = $signed({{(EW-TW){lim[TW-1]}}, lim});
  assign hyst_x  = $signed({{(EW-HW){1'b0}}, hyst});
  assign floor_x = $signed({{(EW-TW+1){1'b1}}, {(TW-1){1'b0}}});
  assign diff_x  = lim_x - hyst_x;
  assign thr     = (diff_x < floor_x) ? floor_x[TW-1:0] : diff_x[TW-1:0];

  assign above    = temp > lim;
  assign released = temp <= thr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
    end else if (upd) begin
      if (above) active <= 1'b1;
      else if (released) active <= 1'b0;
    end
  end

  // R7 / R8: trip above the point
  p_trip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && temp > lim) |=> active);
  // R7 / R8: release at or below the saturated threshold
  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !(temp > lim) && temp <= thr) |=> !active);
  // R10: no beat, no change
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(active));
endmodule

// File: rtl/tlim_status.sv
module tlim_status
  import tlim_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            upd,
  input  logic [ST_W-1:0] cond,
  input  logic            clr,
  input  logic            serviced,
  output logic [ST_W-1:0] status,
  output logic            alert_req
);
  logic [ST_W-1:0] set_vec;
  logic svc_q, alert_n, svc_n;

  assign set_vec = upd ? cond : '0;

  always_comb begin
    alert_n = alert_req;
    if (|set_vec) alert_n = 1'b1;
    else if (alert_req && (svc_q || serviced) && status == '0) alert_n = 1'b0;
    svc_n = alert_n && (svc_q || (serviced && alert_req));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status    <= '0;
      alert_req <= 1'b0;
      svc_q     <= 1'b0;
    end else begin
      status    <= (clr ? '0 : status) | set_vec;
      alert_req <= alert_n;
      svc_q     <= svc_n;
    end
  end

  p_set_sticks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && |cond) |=> ((status & $past(cond)) == $past(cond)));
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((status & $past(status)) == $past(status)));
  p_alert_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && |cond) |=> alert_req);
  p_alert_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (alert_req && status != '0) |=> alert_req);
  p_alert_needs_svc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (alert_req && !svc_q && !serviced) |=> alert_req);
endmodule

// File: rtl/tlim_irq_ctrl.sv
module tlim_irq_ctrl
  import tlim_pkg::*;
#(
  parameter int TW = 8,
  parameter int HW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_valid,
  output logic                 rd_ready,
  input  logic signed [TW-1:0] loc_temp,
  input  logic signed [TW-1:0] rem_temp,
  input  logic signed [TW-1:0] loc_high_lim,
  input  logic signed [TW-1:0] loc_low_lim,
  input  logic signed [TW-1:0] rem_high_lim,
  input  logic signed [TW-1:0] rem_low_lim,
  input  logic signed [TW-1:0] loc_therm_lim,
  input  logic signed [TW-1:0] rem_therm_lim,
  input  logic        [HW-1:0] therm_hyst,
  input  logic                 alert_mask,
  input  logic                 pin2_mode,
  input  logic                 open_fault,
  input  logic                 alert_serviced,
  input  logic                 status_clr,
  output logic        [ST_W-1:0] status,
  output logic                 alert_pd,
  output logic                 therm_pd,
  output logic                 pin2_pd
);
  localparam int N_CMP = 2 * N_CH;

  logic upd, alert_req, therm2;
  logic [ST_W-1:0] cond;
  logic signed [TW-1:0] cmp_t [N_CMP];
  logic signed [TW-1:0] cmp_l [N_CMP];
  logic [N_CMP-1:0] cmp_act;

  assign rd_ready = 1'b1;
  assign upd      = rd_valid & rd_ready;

  always_comb begin
    cond           = '0;
    cond[ST_LHIGH] = loc_temp > loc_high_lim;
    cond[ST_LLOW]  = loc_temp <= loc_low_lim;
    cond[ST_OPEN]  = open_fault;
    cond[ST_RHIGH] = rem_temp > rem_high_lim;
    cond[ST_RLOW]  = rem_temp <= rem_low_lim;
  end

  // slots 0..N_CH-1 compare against trip points, the rest against high limits
  always_comb begin
    cmp_t[0] = loc_temp;  cmp_l[0] = loc_therm_lim;
    cmp_t[1] = rem_temp;  cmp_l[1] = rem_therm_lim;
    cmp_t[2] = loc_temp;  cmp_l[2] = loc_high_lim;
    cmp_t[3] = rem_temp;  cmp_l[3] = rem_high_lim;
  end

  for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
    tlim_hyst_cmp #(.TW(TW), .HW(HW)) u_cmp (
      .clk    (clk),
      .rst_n  (rst_n),
      .upd    (upd),
      .temp   (cmp_t[g]),
      .lim    (cmp_l[g]),
      .hyst   (therm_hyst),
      .active (cmp_act[g])
    );
  end

  tlim_status u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd       (upd),
    .cond      (cond),
    .clr       (status_clr),
    .serviced  (alert_serviced),
    .status    (status),
    .alert_req (alert_req)
  );

  assign therm_pd = |cmp_act[N_CH-1:0];
  assign therm2   = |cmp_act[N_CMP-1:N_CH];
  assign alert_pd = alert_req & ~alert_mask;
  assign pin2_pd  = (pin_mode_e'(pin2_mode) == PIN_THERM2) ? therm2 : alert_pd;

  p_data_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> ($stable(therm_pd) && $stable(therm2)));
endmodule

// File: tb/sim_tlim_irq_ctrl.sv
module sim_tlim_irq_ctrl;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, rd_valid, rd_ready;
  logic signed [7:0] loc_temp, rem_temp, loc_high_lim, loc_low_lim;
  logic signed [7:0] rem_high_lim, rem_low_lim, loc_therm_lim, rem_therm_lim;
  logic [7:0] therm_hyst;
  logic alert_mask, pin2_mode, open_fault, alert_serviced, status_clr;
  logic [4:0] status;
  logic alert_pd, therm_pd, pin2_pd;

  tlim_irq_ctrl u0 (.*);

  int checks = 0, errors = 0;
  bit done = 0;
  logic [4:0] ms;
  logic ma, mp, tl, tr, t2l, t2r;
  logic [31:0] rng = 32'h1234_5678;

  function automatic logic hnext(logic st, int t, int lim, int h);
    int thr = lim - h;
    if (thr < -128) thr = -128;
    if (t > lim) return 1'b1;
    if (t <= thr) return 1'b0;
    return st;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R5 R6 alert", {7'd0, alert_pd}, {7'd0, ma & ~alert_mask});
    chk("R7 therm", {7'd0, therm_pd}, {7'd0, tl | tr});
    chk("R8 pin2", {7'd0, pin2_pd},
        {7'd0, pin2_mode ? (t2l | t2r) : (ma & ~alert_mask)});
    chk("R1 R2 R3 R4 status", {3'd0, status}, {3'd0, ms});
  endtask

  task automatic step(bit v, bit c, bit s);
    int lt, rt, h;
    logic [4:0] cnd, setv, ns;
    logic na;
    rd_valid = v; status_clr = c; alert_serviced = s;
    @(posedge clk);
    lt = loc_temp; rt = rem_temp; h = therm_hyst;
    cnd = {loc_temp > loc_high_lim, loc_temp <= loc_low_lim, open_fault,
           rem_temp > rem_high_lim, rem_temp <= rem_low_lim};
    setv = v ? cnd : 5'd0;
    ns = (c ? 5'd0 : ms) | setv;
    if (|setv) na = 1'b1;
    else if (ma && (mp || s) && ms == 5'd0) na = 1'b0;
    else na = ma;
    mp = na && (mp || (s && ma));
    ma = na; ms = ns;
    if (v) begin
      tl  = hnext(tl,  lt, int'(loc_therm_lim), h);
      tr  = hnext(tr,  rt, int'(rem_therm_lim), h);
      t2l = hnext(t2l, lt, int'(loc_high_lim), h);
      t2r = hnext(t2r, rt, int'(rem_high_lim), h);
    end
    @(negedge clk);
    rd_valid = 0; status_clr = 0; alert_serviced = 0;
    check_all();
  endtask

  function automatic logic [31:0] xs(logic [31:0] x);
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  initial begin
    int hl[3] = '{0, 10, 200};
    int ll[3] = '{85, -100, 127};
    logic [4:0] snap_s;
    logic snap_t;
    rst_n = 0; rd_valid = 0; status_clr = 0; alert_serviced = 0;
    loc_temp = 25; rem_temp = 25; loc_high_lim = 70; loc_low_lim = -55;
    rem_high_lim = 70; rem_low_lim = -55; loc_therm_lim = 85; rem_therm_lim = 85;
    therm_hyst = 10; alert_mask = 0; pin2_mode = 0; open_fault = 0;
    ms = 0; ma = 0; mp = 0; tl = 0; tr = 0; t2l = 0; t2r = 0;
    repeat (3) @(negedge clk);
    chk("R4 reset status", {3'd0, status}, 8'd0);
    chk("R5 reset alert", {7'd0, alert_pd}, 8'd0);
    chk("R7 reset therm", {7'd0, therm_pd}, 8'd0);
    chk("R8 reset pin2", {7'd0, pin2_pd}, 8'd0);
    chk("R10 ready", {7'd0, rd_ready}, 8'd1);
    rst_n = 1;
    @(negedge clk);

    // R1 boundary
    loc_temp = 70; step(1, 0, 0);
    chk("R1 equal to high", {3'd0, status}, 8'd0);
    loc_temp = 71; step(1, 0, 0);
    chk("R1 above high", {3'd0, status}, 8'h10);
    chk("R5 alert set", {7'd0, alert_pd}, 8'd1);
    // R6 service then clear
    loc_temp = 25; step(1, 0, 0);
    step(0, 0, 1);
    chk("R6 service alone", {7'd0, alert_pd}, 8'd1);
    step(0, 1, 0);
    chk("R6 clear edge", {7'd0, alert_pd}, 8'd1);
    step(0, 0, 0);
    chk("R6 released", {7'd0, alert_pd}, 8'd0);
    // R6 clear then service
    loc_temp = 71; step(1, 0, 0);
    loc_temp = 25; step(1, 1, 0);
    chk("R6 clear alone", {7'd0, alert_pd}, 8'd1);
    step(0, 0, 1);
    chk("R6 released second order", {7'd0, alert_pd}, 8'd0);
    // R4 set beats clear
    loc_temp = 71; step(1, 0, 0);
    step(1, 1, 0);
    chk("R4 persisting wins", {3'd0, status}, 8'h10);
    // R2 low boundary
    rem_temp = -55; step(1, 0, 0);
    chk("R2 equal to low", {3'd0, status}, 8'h11);
    // R3 open
    open_fault = 1; step(1, 0, 0);
    chk("R3 open", {3'd0, status}, 8'h15);
    open_fault = 0; loc_temp = 25; rem_temp = 25;
    step(1, 1, 1); step(0, 0, 1); step(0, 0, 0);
    // R5 mask, R9 unmaskable
    alert_mask = 1; pin2_mode = 1; loc_temp = 90; step(1, 0, 0);
    chk("R5 masked alert", {7'd0, alert_pd}, 8'd0);
    chk("R9 therm unmasked", {7'd0, therm_pd}, 8'd1);
    chk("R9 therm2 unmasked", {7'd0, pin2_pd}, 8'd1);
    alert_mask = 0;
    // R10 idle inputs ignored
    snap_s = status; snap_t = therm_pd;
    loc_temp = -128; rem_temp = 127; open_fault = 1; step(0, 0, 0);
    chk("R10 status idle", {3'd0, status}, {3'd0, snap_s});
    chk("R10 therm idle", {7'd0, therm_pd}, {7'd0, snap_t});
    open_fault = 0;

    // R7 R8 sweeps
    for (int hi = 0; hi < 3; hi++) begin
      for (int li = 0; li < 3; li++) begin
        therm_hyst = 8'(hl[hi]); pin2_mode = (hi != 1);
        for (int ch = 0; ch < 2; ch++) begin
          loc_therm_lim = 127; rem_therm_lim = 127; loc_high_lim = 127; rem_high_lim = 127;
          loc_temp = 0; rem_temp = 0;
          if (ch == 0) begin loc_therm_lim = 8'(ll[li]); loc_high_lim = 8'(ll[(li+1)%3]); end
          else begin rem_therm_lim = 8'(ll[li]); rem_high_lim = 8'(ll[(li+2)%3]); end
          for (int t = -128; t <= 127; t++) begin
            if (ch == 0) loc_temp = 8'(t); else rem_temp = 8'(t);
            step(1, 0, 0);
          end
          for (int t = 127; t >= -128; t--) begin
            if (ch == 0) loc_temp = 8'(t); else rem_temp = 8'(t);
            step(1, 0, 0);
          end
          step(0, 1, 1);
        end
      end
    end

    // mixed pseudo-random traffic
    for (int i = 0; i < 4000; i++) begin
      rng = xs(rng);
      loc_temp = 8'(rng[7:0]); rem_temp = 8'(rng[15:8]);
      open_fault = rng[16] & rng[17];
      if (rng[18] & rng[19]) begin
        rng = xs(rng);
        loc_high_lim = 8'(rng[7:0]); rem_high_lim = 8'(rng[15:8]);
        loc_low_lim = 8'(rng[23:16]); rem_low_lim = -8'sd100;
        loc_therm_lim = 8'(rng[31:24]); rem_therm_lim = 8'(rng[11:4]);
        therm_hyst = 8'(rng[27:20]);
        alert_mask = rng[1]; pin2_mode = rng[2];
        rng = xs(rng);
      end
      step(rng[20], rng[21] & rng[22], rng[23] & rng[24]);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #700000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog all requirements actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule